// File: doc/BRIEF.md
# Image Sensor Readout Sequencer

This block generates the digital clocking for a two-dimensional charge-coupled image array and for the converter that digitizes its output. One pulse on the start input runs a full frame. The array is exposed for a fixed number of cycles. The rows are then moved one at a time into the horizontal serial register. That register is shifted out one pixel per cycle toward the output amplifier. One clock cycle after every horizontal shift, a sample strobe tells the converter that the pixel is ready. Markers on that strobe identify the last pixel of a line and the last pixel of the frame.

The block has two readout schemes, selected per frame:

- **Full-frame:** there is no shielded storage, so the mechanical shutter closes as the exposure ends. It stays shut until all charge has left the array.
- **Interline:** every photodiode charge is first dumped into shielded vertical storage with a single transfer pulse. The shutter may then remain open while the rows are read out.

Array height, array width and exposure length are elaboration parameters.

Top module: `ccd_seq_top`

## Requirements
- R1: While rst_ni is low, and after reset is released with no start, every output is 0.
- R2: A start_i high seen at a clock edge while busy_o is 0 makes busy_o go high in the next cycle. From that cycle on, shutter_o is 1 for exactly EXP_CYCLES cycles, with no transfer, vertical or horizontal pulse during them.
- R3: With mode_i = 0 (full-frame) latched at start, shutter_o is 0 from the cycle after exposure until the frame ends. The first vclk_o pulse comes in the cycle right after the last exposure cycle.
- R4: With mode_i = 1 (interline) latched at start, xfer_o is high for exactly one cycle, right after the last exposure cycle. The first vclk_o pulse follows in the next cycle. shutter_o stays 1 through the last hclk_o cycle and is 0 afterwards.
- R5: Each of the ROWS rows is read as one vclk_o cycle followed by COLS consecutive hclk_o cycles. No two of xfer_o, vclk_o and hclk_o are high together.
- R6: adc_strobe_o is high in exactly the cycles that follow an hclk_o cycle, giving ROWS*COLS strobes per frame.
- R7: eol_o is high together with the strobe of the last column of each row. eof_o is high only with the strobe of the last column of the last row.
- R8: busy_o stays high up to and including the cycle of the final strobe, and is 0 in the cycle after it.
- R9: start_i is ignored while busy_o is 1, including the final strobe cycle. mode_i changes after the start edge have no effect on the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame (accepted only while not busy) |
| mode_i | input | 1 | 0 = full-frame, 1 = interline; latched at start |
| busy_o | output | 1 | Frame in progress |
| shutter_o | output | 1 | 1 = mechanical shutter open |
| xfer_o | output | 1 | Photodiode-to-storage transfer pulse (interline) |
| vclk_o | output | 1 | Vertical shift pulse, one row into the horizontal register |
| hclk_o | output | 1 | Horizontal shift pulse, one pixel to the amplifier |
| adc_strobe_o | output | 1 | Converter sample strobe |
| eol_o | output | 1 | Last pixel of a line, with the strobe |
| eof_o | output | 1 | Last pixel of the frame, with the strobe |

## Verification
The bench checks every cycle of whole frames against a timing model derived from the requirements, in both modes.

- **Shutter closing:** a design that lets light in during full-frame readout would hold shutter_o high past the exposure.
- **Transfer pulse:** a design that omits the interline transfer, or repeats it, would shift every later pulse by a cycle.
- **Final strobe:** the last strobe arrives after the state machine has gone idle. A design that drops busy_o too early would lose that strobe's busy cycle. It would also accept a restart poked in that same cycle.
- **Mode input:** a design that tracks mode_i live instead of latching it would switch shutter behaviour mid-frame while mode_i toggles.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXPOSE,
    ST_XFER,
    ST_VSHIFT,
    ST_HSHIFT
  } seq_state_e;

  function automatic int cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ccd_seq_cnt.sv
module ccd_seq_cnt #(
  parameter int MAX = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int W = ccd_seq_pkg::cnt_w(MAX);
  localparam logic [W-1:0] LAST = W'(MAX - 1);

  logic [W-1:0] val_q;

  assign last_o = (val_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (clr_i)  val_q <= '0;
    else if (inc_i)  val_q <= last_o ? '0 : val_q + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !clr_i && last_o |=> val_q == '0); // R5

endmodule

// File: rtl/ccd_seq_ctrl.sv
module ccd_seq_ctrl
  import ccd_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       mode_i,
  input  logic       idle_ok_i,
  input  logic       exp_last_i,
  input  logic       col_last_i,
  input  logic       row_last_i,
  output seq_state_e state_o,
  output logic       shutter_o,
  output logic       xfer_o,
  output logic       vclk_o,
  output logic       hclk_o
);
  seq_state_e state_q, state_d;
  logic       interline_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i && idle_ok_i) state_d = ST_EXPOSE;
      ST_EXPOSE: if (exp_last_i) state_d = interline_q ? ST_XFER : ST_VSHIFT;
      ST_XFER:   state_d = ST_VSHIFT;
      ST_VSHIFT: state_d = ST_HSHIFT;
      ST_HSHIFT: if (col_last_i) state_d = row_last_i ? ST_IDLE : ST_VSHIFT;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      interline_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i && idle_ok_i) interline_q <= mode_i;
    end
  end

  // Interline keeps the shutter open during readout; the charge sits in shielded storage
  assign shutter_o = (state_q == ST_EXPOSE) ||
                     (interline_q && (state_q == ST_XFER || state_q == ST_VSHIFT ||
                                      state_q == ST_HSHIFT));
  assign xfer_o  = (state_q == ST_XFER);
  assign vclk_o  = (state_q == ST_VSHIFT);
  assign hclk_o  = (state_q == ST_HSHIFT);
  assign state_o = state_q;

  AST_XFER_AFTER_EXP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> $past(state_q) == ST_EXPOSE); // R4
  AST_XFER_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |=> !xfer_o && vclk_o); // R4
  AST_V_BEFORE_H: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hclk_o) |-> $past(vclk_o)); // R5
  AST_FF_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vclk_o || hclk_o) && !interline_q |-> !shutter_o); // R3
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_IDLE && $past(state_q) != ST_IDLE |-> $stable(interline_q)); // R9

endmodule

// File: rtl/ccd_seq_strobe.sv
module ccd_seq_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hclk_i,
  input  logic col_last_i,
  input  logic row_last_i,
  output logic strobe_o,
  output logic eol_o,
  output logic eof_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_o <= 1'b0;
      eol_o    <= 1'b0;
      eof_o    <= 1'b0;
    end else begin
      strobe_o <= hclk_i;
      eol_o    <= hclk_i && col_last_i;
      eof_o    <= hclk_i && col_last_i && row_last_i;
    end
  end

  AST_STROBE_AFTER_H: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hclk_i |=> strobe_o); // R6
  AST_EOF_IN_EOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> eol_o && strobe_o); // R7

endmodule

// File: rtl/ccd_seq_top.sv
module ccd_seq_top
  import ccd_seq_pkg::*;
#(
  parameter int ROWS       = 4,
  parameter int COLS       = 6,
  parameter int EXP_CYCLES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mode_i,
  output logic busy_o,
  output logic shutter_o,
  output logic xfer_o,
  output logic vclk_o,
  output logic hclk_o,
  output logic adc_strobe_o,
  output logic eol_o,
  output logic eof_o
);
  seq_state_e state;
  logic exp_last, col_last, row_last;

  ccd_seq_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .idle_ok_i  (!adc_strobe_o),
    .exp_last_i (exp_last),
    .col_last_i (col_last),
    .row_last_i (row_last),
    .state_o    (state),
    .shutter_o  (shutter_o),
    .xfer_o     (xfer_o),
    .vclk_o     (vclk_o),
    .hclk_o     (hclk_o)
  );

  ccd_seq_cnt #(.MAX(EXP_CYCLES)) u_exp_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state != ST_EXPOSE),
    .inc_i  (state == ST_EXPOSE),
    .last_o (exp_last)
  );

  ccd_seq_cnt #(.MAX(COLS)) u_col_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state != ST_HSHIFT),
    .inc_i  (state == ST_HSHIFT),
    .last_o (col_last)
  );

  ccd_seq_cnt #(.MAX(ROWS)) u_row_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state == ST_IDLE),
    .inc_i  (state == ST_HSHIFT && col_last),
    .last_o (row_last)
  );

  ccd_seq_strobe u_strobe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hclk_i     (hclk_o),
    .col_last_i (col_last),
    .row_last_i (row_last),
    .strobe_o   (adc_strobe_o),
    .eol_o      (eol_o),
    .eof_o      (eof_o)
  );

  // The final strobe trails the return to idle by one cycle
  assign busy_o = (state != ST_IDLE) || adc_strobe_o;

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hclk_o |=> busy_o); // R8
  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> !busy_o); // R9

endmodule

// File: tb/tb_ccd_seq_top.sv
module tb_ccd_seq_top;
  localparam int ROWS = 4;
  localparam int COLS = 6;
  localparam int EXP  = 10;
  localparam int LINE = COLS + 1;

  // {mode, toggle mode_i during run, hold start_i during run}
  localparam logic [2:0] VEC [0:3] = '{3'b000, 3'b100, 3'b011, 3'b111};

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, mode_i = 1'b0;
  logic busy_o, shutter_o, xfer_o, vclk_o, hclk_o, adc_strobe_o, eol_o, eof_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ccd_seq_top #(.ROWS(ROWS), .COLS(COLS), .EXP_CYCLES(EXP)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .busy_o(busy_o), .shutter_o(shutter_o), .xfer_o(xfer_o), .vclk_o(vclk_o),
    .hclk_o(hclk_o), .adc_strobe_o(adc_strobe_o), .eol_o(eol_o), .eof_o(eof_o)
  );

  function automatic logic [7:0] outs();
    return {busy_o, shutter_o, xfer_o, vclk_o, hclk_o, adc_strobe_o, eol_o, eof_o};
  endfunction

  // Expected {busy,shutter,xfer,vclk,hclk,strobe,eol,eof} n cycles after the start edge
  function automatic logic [7:0] model(int n, bit m);
    int off, last, k, kp;
    logic b, s, x, v, h, st, el, ef;
    off  = EXP + (m ? 1 : 0);
    last = off + ROWS * LINE;
    {b, s, x, v, h, st, el, ef} = '0;
    if (n < EXP) s = 1'b1;
    if (m && n == EXP) begin x = 1'b1; s = 1'b1; end
    k = n - off;
    if (k >= 0 && k < ROWS * LINE) begin
      if (k % LINE == 0) v = 1'b1; else h = 1'b1;
      if (m) s = 1'b1;
    end
    kp = k - 1;
    if (kp >= 0 && kp < ROWS * LINE && kp % LINE != 0) begin
      st = 1'b1;
      if (kp % LINE == COLS) begin
        el = 1'b1;
        if (kp / LINE == ROWS - 1) ef = 1'b1;
      end
    end
    b = (n <= last);
    return {b, s, x, v, h, st, el, ef};
  endfunction

  task automatic chk(string tag, int n, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s n=%0d act=%b exp=%b", tag, n, act, exp);
    end
  endtask

  task automatic chk_cnt(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s count act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic run_frame(bit m, bit tog, bit poke);
    int last, nv, nh, ns, nl, nf;
    string tag;
    last = EXP + (m ? 1 : 0) + ROWS * LINE;
    nv = 0; nh = 0; ns = 0; nl = 0; nf = 0;
    mode_i  = m;
    start_i = 1'b1;
    @(negedge clk);
    start_i = poke;
    for (int n = 0; n <= last + 3; n++) begin
      if (n < EXP)                 tag = "R2";
      else if (m && n == EXP)      tag = "R4";
      else if (n == last)          tag = "R8";
      else if (n > last)           tag = "R9";
      else                         tag = m ? "R4" : "R3";
      chk(tag, n, outs(), model(n, m));
      nv += int'(vclk_o); nh += int'(hclk_o); ns += int'(adc_strobe_o);
      nl += int'(eol_o);  nf += int'(eof_o);
      if (tog) mode_i = ~mode_i;
      start_i = poke && (n < last + 1);
      @(negedge clk);
    end
    start_i = 1'b0;
    chk_cnt("R5 vclk", nv, ROWS);
    chk_cnt("R5 hclk", nh, ROWS * COLS);
    chk_cnt("R6 strobe", ns, ROWS * COLS);
    chk_cnt("R7 eol", nl, ROWS);
    chk_cnt("R7 eof", nf, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 0, outs(), 8'h00);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", 0, outs(), 8'h00);

    for (int i = 0; i < 4; i++) run_frame(VEC[i][2], VEC[i][1], VEC[i][0]);

    // R1: reset in the middle of an exposure returns everything to 0
    mode_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2", 3, outs(), model(3, 1'b0));
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1", 0, outs(), 8'h00);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", 0, outs(), 8'h00);

    // R2: a frame after reset still runs normally
    run_frame(1'b1, 1'b0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule